// File: doc/BRIEF.md
# Dual-Action Timer Capture/Match Channel

This block is a single timer channel with one input pin and one output pin. It watches two 24-bit time bases that are supplied from outside. It has two capture registers, two match registers, two transition latches and two sticky match flags. The input is synchronised and then goes through a digital filter, which can be bypassed. Edges of the resulting level are detected, and each edge can be routed to either of two transition slots. Each slot captures the time base it selects and sets its own latch. The two slots are independent, so the second one may fire before the first.

Each match unit compares a selected time base against its value. The comparison is either greater-or-equal or exact equality. When a match fires, the unit sets its flag and applies a programmed action to the output pin. Software clears each latch and each flag on its own. A service request is raised whenever any flag that software has enabled for requests is set.

A mode bit selects single-action operation, in which only slot 1 and match 1 are live, or double-action operation, in which both are live. A second mode bit slows all channel logic to every other clock.

Top module: `tmr_dual_channel`

## Requirements
- R1: With the filter bypassed and full rate selected, a pin change appears on `pin_in_sync` after the second rising clock edge. An edge armed in slot 1 sets `tdl1` on the third rising edge, counting the first edge after the pin change as the first.
- R2: With the filter in use, a new pin level is accepted only after it has differed from the accepted level for `flt_len`+1 consecutive enabled clocks. A pulse that is shorter than this is never detected.
- R3: When `half_rate` is 1, the channel and filter advance only on every second clock. With the filter at `flt_len`=1, latch 1 is still clear six edges after a pin change and is set by the eighth.
- R4: The edge selects use this encoding: 00 = none, 01 = rising, 10 = falling, 11 = both. On a selected edge, a slot whose latch is clear captures the time base chosen by its select bit (0 = `tbase_a`, 1 = `tbase_b`) and sets its latch. While the latch stays set, further edges leave the capture unchanged.
- R5: Slot 2 can detect an edge and set `tdl2` while `tdl1` is clear. A later detection in slot 1 then leaves `tdl2` set.
- R6: `clr_tdl1` clears only `tdl1` and `clr_tdl2` clears only `tdl2`.
- R7: A match fires when the selected time base is greater than or equal to the match value (`mt_eq_only`=0), or exactly equal to it (`mt_eq_only`=1). The flag is set on the next enabled edge. It then holds, and the match does not fire again until the flag is cleared.
- R8: The output action uses this encoding: 00 = none, 01 = set, 10 = clear, 11 = toggle. When both matches fire on the same edge, the match 1 action is applied first and the match 2 action is applied to its result.
- R9: With `dbl_mode`=0, `tdl2` and `mf2` never become set.
- R10: `srv_req` is the OR of the flags selected by `req_en`. Bit 0 selects `tdl1`, bit 1 selects `tdl2`, bit 2 selects `mf1` and bit 3 selects `mf2`.
- R11: A clear that lands on the same enabled edge as a new event of that latch or flag does not win. The latch or flag stays set, and the capture or output action is taken again.
- R12: After reset, the latches, flags, captures, `pin_out` and `srv_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| half_rate | input | 1 | 1: channel logic advances every second clock |
| dbl_mode | input | 1 | 1: double action (slot 2 and match 2 live) |
| tbase_a | input | 24 | Time base A |
| tbase_b | input | 24 | Time base B |
| pin_in | input | 1 | Channel input pin |
| pin_out | output | 1 | Channel output pin |
| pin_in_sync | output | 1 | Synchronised input pin state for the host |
| flt_bypass | input | 1 | 1: the synchronised pin drives edge detection directly |
| flt_len | input | 2 | Filter stability count minus one |
| edge_sel1 | input | 2 | Edge select for slot 1 |
| edge_sel2 | input | 2 | Edge select for slot 2 |
| cap_tb_sel1 | input | 1 | Time base captured by slot 1 |
| cap_tb_sel2 | input | 1 | Time base captured by slot 2 |
| match_val1 | input | 24 | Match 1 value |
| match_val2 | input | 24 | Match 2 value |
| mt_tb_sel1 | input | 1 | Time base compared by match 1 |
| mt_tb_sel2 | input | 1 | Time base compared by match 2 |
| mt_eq_only1 | input | 1 | Match 1 equal-only mode |
| mt_eq_only2 | input | 1 | Match 2 equal-only mode |
| mt_en1 | input | 1 | Match 1 enable |
| mt_en2 | input | 1 | Match 2 enable |
| mt_act1 | input | 2 | Match 1 output action |
| mt_act2 | input | 2 | Match 2 output action |
| clr_tdl1 | input | 1 | Clear latch 1 |
| clr_tdl2 | input | 1 | Clear latch 2 |
| clr_mf1 | input | 1 | Clear match flag 1 |
| clr_mf2 | input | 1 | Clear match flag 2 |
| req_en | input | 4 | Service request enables |
| cap1 | output | 24 | Capture register 1 |
| cap2 | output | 24 | Capture register 2 |
| tdl1 | output | 1 | Transition latch 1 |
| tdl2 | output | 1 | Transition latch 2 |
| mf1 | output | 1 | Match flag 1 |
| mf2 | output | 1 | Match flag 2 |
| srv_req | output | 1 | Service request |

## Verification
A software clear can land on the same edge as a new event for that latch or flag. The design must then keep the event rather than lose it. To provoke this, the bench raises the clear exactly on the edge where a detected transition, or a true comparison, is evaluated. It then judges the result from the captured value, the flag and the output pin. The two match actions can also fall on one edge. The bench forces this by re-arming both flags together and then compares `pin_out` with the result of applying the two actions in order.

// File: rtl/tmr_dual_channel.sv
module tmr_dual_channel #(
  parameter int TW = 24,
  parameter int FW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_rate,
  input  logic          dbl_mode,
  input  logic [TW-1:0] tbase_a,
  input  logic [TW-1:0] tbase_b,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_in_sync,
  input  logic          flt_bypass,
  input  logic [FW-1:0] flt_len,
  input  logic [1:0]    edge_sel1,
  input  logic [1:0]    edge_sel2,
  input  logic          cap_tb_sel1,
  input  logic          cap_tb_sel2,
  input  logic [TW-1:0] match_val1,
  input  logic [TW-1:0] match_val2,
  input  logic          mt_tb_sel1,
  input  logic          mt_tb_sel2,
  input  logic          mt_eq_only1,
  input  logic          mt_eq_only2,
  input  logic          mt_en1,
  input  logic          mt_en2,
  input  logic [1:0]    mt_act1,
  input  logic [1:0]    mt_act2,
  input  logic          clr_tdl1,
  input  logic          clr_tdl2,
  input  logic          clr_mf1,
  input  logic          clr_mf2,
  input  logic [3:0]    req_en,
  output logic [TW-1:0] cap1,
  output logic [TW-1:0] cap2,
  output logic          tdl1,
  output logic          tdl2,
  output logic          mf1,
  output logic          mf2,
  output logic          srv_req
);

  function automatic logic hit(input logic [1:0] s, input logic r, input logic f);
    return (s[0] & r) | (s[1] & f);
  endfunction

  function automatic logic act(input logic [1:0] a, input logic p);
    case (a)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~p;
      default: return p;
    endcase
  endfunction

  function automatic logic cmp(input logic [TW-1:0] t, input logic [TW-1:0] v, input logic eq);
    return eq ? (t == v) : (t >= v);
  endfunction

  logic          ph, s1, s2, flt, prv;
  logic [FW-1:0] cnt;
  logic          tick, lvl, rise, fall;
  logic          tr1, tr2, ev1, ev2, p1, p2;

  assign tick        = ~half_rate | ph;
  assign pin_in_sync = s2;
  assign lvl         = flt_bypass ? s2 : flt;
  assign rise        = lvl & ~prv;
  assign fall        = ~lvl & prv;

  assign tr1 = tick & hit(edge_sel1, rise, fall) & (~tdl1 | clr_tdl1);
  assign tr2 = tick & dbl_mode & hit(edge_sel2, rise, fall) & (~tdl2 | clr_tdl2);

  assign ev1 = tick & mt_en1 & (~mf1 | clr_mf1) &
               cmp(mt_tb_sel1 ? tbase_b : tbase_a, match_val1, mt_eq_only1);
  assign ev2 = tick & dbl_mode & mt_en2 & (~mf2 | clr_mf2) &
               cmp(mt_tb_sel2 ? tbase_b : tbase_a, match_val2, mt_eq_only2);

  assign p1 = ev1 ? act(mt_act1, pin_out) : pin_out;
  assign p2 = ev2 ? act(mt_act2, p1) : p1;

  assign srv_req = |(req_en & {mf2, mf1, tdl2, tdl1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0;
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      ph <= ~ph;
      s1 <= pin_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt <= 1'b0;
      cnt <= '0;
      prv <= 1'b0;
    end else if (tick) begin
      prv <= lvl;
      if (s2 == flt) begin
        cnt <= '0;
      end else if (cnt == flt_len) begin
        flt <= s2;
        cnt <= '0;
      end else begin
        cnt <= cnt + FW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdl1 <= 1'b0;
      tdl2 <= 1'b0;
      cap1 <= '0;
      cap2 <= '0;
    end else begin
      tdl1 <= tr1 | (tdl1 & ~clr_tdl1);
      tdl2 <= tr2 | (tdl2 & ~clr_tdl2);
      if (tr1) cap1 <= cap_tb_sel1 ? tbase_b : tbase_a;
      if (tr2) cap2 <= cap_tb_sel2 ? tbase_b : tbase_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf1     <= 1'b0;
      mf2     <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      mf1     <= ev1 | (mf1 & ~clr_mf1);
      mf2     <= ev2 | (mf2 & ~clr_mf2);
      pin_out <= p2;
    end
  end

endmodule

module tmr_dual_channel_chk #(
  parameter int TW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbl_mode,
  input logic          clr_tdl1,
  input logic          clr_tdl2,
  input logic          clr_mf1,
  input logic          clr_mf2,
  input logic          tdl1,
  input logic          tdl2,
  input logic          mf1,
  input logic          mf2,
  input logic [TW-1:0] cap1,
  input logic [TW-1:0] cap2,
  input logic          pin_out
);

  // R4
  cap1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tdl1 && !clr_tdl1) |=> $stable(cap1));

  // R4
  cap2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tdl2 && !clr_tdl2) |=> $stable(cap2));

  // R6
  clr1_keeps_tdl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tdl1 && !clr_tdl2 && tdl2) |=> tdl2);

  // R6
  clr2_keeps_tdl1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tdl2 && !clr_tdl1 && tdl1) |=> tdl1);

  // R7
  mf1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf1 && !clr_mf1) |=> mf1);

  // R8
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mf1 && mf2 && !clr_mf1 && !clr_mf2) |=> $stable(pin_out));

  // R9
  single_no_tdl2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_mode && !tdl2) |=> !tdl2);

  // R9
  single_no_mf2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_mode && !mf2) |=> !mf2);

endmodule

bind tmr_dual_channel tmr_dual_channel_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode),
  .clr_tdl1(clr_tdl1), .clr_tdl2(clr_tdl2), .clr_mf1(clr_mf1), .clr_mf2(clr_mf2),
  .tdl1(tdl1), .tdl2(tdl2), .mf1(mf1), .mf2(mf2),
  .cap1(cap1), .cap2(cap2), .pin_out(pin_out)
);

// File: tb/tmr_dual_channel_tb.sv
module tmr_dual_channel_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic half_rate, dbl_mode, pin_in, flt_bypass;
  logic [23:0] tbase_a, tbase_b, match_val1, match_val2;
  logic [1:0] flt_len, edge_sel1, edge_sel2, mt_act1, mt_act2;
  logic cap_tb_sel1, cap_tb_sel2, mt_tb_sel1, mt_tb_sel2;
  logic mt_eq_only1, mt_eq_only2, mt_en1, mt_en2;
  logic clr_tdl1, clr_tdl2, clr_mf1, clr_mf2;
  logic [3:0] req_en;
  logic pin_out, pin_in_sync, tdl1, tdl2, mf1, mf2, srv_req;
  logic [23:0] cap1, cap2;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_dual_channel u_dut (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .dbl_mode(dbl_mode),
    .tbase_a(tbase_a), .tbase_b(tbase_b), .pin_in(pin_in), .pin_out(pin_out),
    .pin_in_sync(pin_in_sync), .flt_bypass(flt_bypass), .flt_len(flt_len),
    .edge_sel1(edge_sel1), .edge_sel2(edge_sel2),
    .cap_tb_sel1(cap_tb_sel1), .cap_tb_sel2(cap_tb_sel2),
    .match_val1(match_val1), .match_val2(match_val2),
    .mt_tb_sel1(mt_tb_sel1), .mt_tb_sel2(mt_tb_sel2),
    .mt_eq_only1(mt_eq_only1), .mt_eq_only2(mt_eq_only2),
    .mt_en1(mt_en1), .mt_en2(mt_en2), .mt_act1(mt_act1), .mt_act2(mt_act2),
    .clr_tdl1(clr_tdl1), .clr_tdl2(clr_tdl2), .clr_mf1(clr_mf1), .clr_mf2(clr_mf2),
    .req_en(req_en), .cap1(cap1), .cap2(cap2), .tdl1(tdl1), .tdl2(tdl2),
    .mf1(mf1), .mf2(mf2), .srv_req(srv_req)
  );

  function automatic logic exp_cmp(input logic [23:0] t, input logic [23:0] v, input logic eq);
    return eq ? (t == v) : (t >= v);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_tdl1 = 1; clr_tdl2 = 1; clr_mf1 = 1; clr_mf2 = 1;
    nclk(1);
    clr_tdl1 = 0; clr_tdl2 = 0; clr_mf1 = 0; clr_mf2 = 0;
  endtask

  task automatic park();
    edge_sel1 = 2'b00; edge_sel2 = 2'b00; pin_in = 0;
    nclk(8);
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] t, tb2, v;
    logic e, s, pv;
    void'($urandom(32'h5eed));
    half_rate = 0; dbl_mode = 1; pin_in = 0; flt_bypass = 1; flt_len = 0;
    tbase_a = 0; tbase_b = 0; match_val1 = 0; match_val2 = 0;
    edge_sel1 = 0; edge_sel2 = 0; mt_act1 = 0; mt_act2 = 0;
    cap_tb_sel1 = 0; cap_tb_sel2 = 0; mt_tb_sel1 = 0; mt_tb_sel2 = 0;
    mt_eq_only1 = 0; mt_eq_only2 = 0; mt_en1 = 0; mt_en2 = 0;
    clr_tdl1 = 0; clr_tdl2 = 0; clr_mf1 = 0; clr_mf2 = 0; req_en = 0;
    nclk(3);
    rst_n = 1;
    nclk(1);
    // R12
    chk("R12 flags", {tdl1, tdl2, mf1, mf2, pin_out, srv_req}, 0);
    chk("R12 cap1", cap1, 0);
    chk("R12 cap2", cap2, 0);

    // R1 and R4: bypassed latency and capture
    tbase_a = 24'h123456; tbase_b = 24'hABCDEF; edge_sel1 = 2'b01;
    pin_in = 1;
    nclk(2);
    chk("R1 sync", pin_in_sync, 1);
    chk("R1 early", tdl1, 0);
    nclk(1);
    chk("R1 latched", tdl1, 1);
    chk("R4 capture", cap1, 24'h123456);
    tbase_a = 24'h000111; pin_in = 0; nclk(4); pin_in = 1; nclk(4);
    chk("R4 blocked", cap1, 24'h123456);
    park();
    chk("R6 cleared", tdl1, 0);

    // R5 unordered slots
    edge_sel1 = 2'b10; edge_sel2 = 2'b01; cap_tb_sel2 = 1;
    tbase_a = 24'h00A001; tbase_b = 24'h00B001;
    pin_in = 1; nclk(4);
    chk("R5 tdl2 first", {tdl1, tdl2}, 2'b01);
    chk("R5 cap2", cap2, 24'h00B001);
    tbase_a = 24'h00A002; pin_in = 0; nclk(4);
    chk("R5 both", {tdl1, tdl2}, 2'b11);
    chk("R5 cap1", cap1, 24'h00A002);
    // R10
    req_en = 4'b0001; #1;
    chk("R10 tdl1 req", srv_req, 1);
    // R6
    clr_tdl1 = 1; nclk(1); clr_tdl1 = 0;
    chk("R6 only tdl1", {tdl1, tdl2}, 2'b01);
    #1;
    chk("R10 masked", srv_req, 0);
    req_en = 4'b0010; #1;
    chk("R10 tdl2 req", srv_req, 1);
    req_en = 0;
    // R11 clear on the detection edge of slot 2
    tbase_b = 24'h00B003; pin_in = 1; nclk(2);
    clr_tdl2 = 1; nclk(1); clr_tdl2 = 0;
    chk("R11 tdl2 kept", tdl2, 1);
    chk("R11 recapture", cap2, 24'h00B003);
    park();

    // R2 filter
    flt_bypass = 0; flt_len = 3; edge_sel1 = 2'b01;
    pin_in = 1; nclk(3); pin_in = 0; nclk(6);
    chk("R2 glitch", tdl1, 0);
    flt_len = 2; pin_in = 1; nclk(5);
    chk("R2 early", tdl1, 0);
    nclk(1);
    chk("R2 accepted", tdl1, 1);
    park();

    // R3 half rate
    half_rate = 1; flt_len = 1; edge_sel1 = 2'b01;
    pin_in = 1; nclk(6);
    chk("R3 slowed", tdl1, 0);
    nclk(2);
    chk("R3 latched", tdl1, 1);
    half_rate = 0;
    park();
    flt_bypass = 1;

    // R7 compare modes
    tbase_a = 999; match_val1 = 1000; mt_en1 = 1; nclk(1);
    chk("R7 below", mf1, 0);
    tbase_a = 1005; nclk(1);
    chk("R7 ge", mf1, 1);
    mt_eq_only1 = 1; clr_mf1 = 1; nclk(1); clr_mf1 = 0;
    chk("R7 eq miss", mf1, 0);
    tbase_a = 1000; nclk(1);
    chk("R7 eq hit", mf1, 1);
    mt_tb_sel1 = 1; tbase_b = 5; clr_mf1 = 1; nclk(1); clr_mf1 = 0;
    chk("R7 tb select", mf1, 0);

    // R8 actions, fired by re-arming clears (R11)
    mt_tb_sel1 = 0; mt_eq_only1 = 0; tbase_a = 2000; match_val1 = 100;
    mt_act1 = 2'b01; clr_mf1 = 1; nclk(1); clr_mf1 = 0;
    chk("R8 set", pin_out, 1);
    mt_act1 = 2'b10; clr_mf1 = 1; nclk(1); clr_mf1 = 0;
    chk("R8 clear", pin_out, 0);
    mt_act1 = 2'b11; clr_mf1 = 1; nclk(1); clr_mf1 = 0;
    chk("R8 toggle", pin_out, 1);
    clr_mf1 = 1; nclk(1); clr_mf1 = 0;
    chk("R11 refire pin", pin_out, 0);
    chk("R11 flag kept", mf1, 1);
    nclk(4);
    chk("R7 fires once", pin_out, 0);
    mt_en2 = 1; match_val2 = 100; mt_act1 = 2'b01; mt_act2 = 2'b11;
    clr_mf1 = 1; clr_mf2 = 1; nclk(1); clr_mf1 = 0; clr_mf2 = 0;
    chk("R8 order set-toggle", pin_out, 0);
    chk("R8 both flags", {mf1, mf2}, 2'b11);
    mt_act1 = 2'b10; mt_act2 = 2'b01;
    clr_mf1 = 1; clr_mf2 = 1; nclk(1); clr_mf1 = 0; clr_mf2 = 0;
    chk("R8 order clear-set", pin_out, 1);
    req_en = 4'b1000; #1;
    chk("R10 mf2 req", srv_req, 1);
    req_en = 4'b0100; #1;
    chk("R10 mf1 req", srv_req, 1);
    req_en = 0;

    // R9 single action
    dbl_mode = 0; mt_act1 = 0; mt_act2 = 0;
    clr_mf1 = 1; clr_mf2 = 1; nclk(1); clr_mf1 = 0; clr_mf2 = 0;
    edge_sel1 = 2'b01; edge_sel2 = 2'b01; clr_tdl1 = 1; clr_tdl2 = 1; nclk(1);
    clr_tdl1 = 0; clr_tdl2 = 0; pin_in = 1; nclk(4);
    chk("R9 mf", {mf1, mf2}, 2'b10);
    chk("R9 tdl", {tdl1, tdl2}, 2'b10);
    dbl_mode = 1; mt_en2 = 0;
    park();

    // R7/R8 random compare against bench model
    mt_act1 = 2'b11;
    for (int i = 0; i < 300; i++) begin
      t = 24'($urandom); tb2 = 24'($urandom); s = 1'($urandom);
      v = ($urandom % 4 == 0) ? (s ? tb2 : t) : 24'($urandom);
      e = 1'($urandom);
      pv = pin_out;
      tbase_a = t; tbase_b = tb2; match_val1 = v; mt_eq_only1 = e; mt_tb_sel1 = s;
      clr_mf1 = 1;
      nclk(1);
      chk("R7 random flag", mf1, exp_cmp(s ? tb2 : t, v, e));
      chk("R8 random pin", pin_out, pv ^ exp_cmp(s ? tb2 : t, v, e));
    end
    clr_mf1 = 0; mt_en1 = 0;

    // R4 random capture on both edges
    edge_sel1 = 2'b11;
    for (int i = 0; i < 40; i++) begin
      clr_tdl1 = 1; nclk(1); clr_tdl1 = 0;
      t = 24'($urandom); tb2 = 24'($urandom); s = 1'($urandom);
      tbase_a = t; tbase_b = tb2; cap_tb_sel1 = s;
      pin_in = ~pin_in;
      nclk(3);
      chk("R4 random latch", tdl1, 1);
      chk("R4 random capture", cap1, s ? tb2 : t);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule